// File: doc/BRIEF.md
# Century Rollover and RTC-Well Status

This block sits next to the real-time-clock register file and watches every write or clock update that lands on the year register. The year is held in BCD, so the block remembers whether the last year value was 99h. When the next year value is 00h, it counts that as a century rollover. A rollover always sets a sticky new-century status bit. It also produces a one-cycle system-management interrupt request, but only when the platform reports the fully-on power state. In any sleep state the status bit records the event and no request is issued.

The block also owns the reset of the RTC power well. While the active-low RTC reset input is low at a clock edge, the block does four things: it sets a sticky RTC-power status bit, clears the new-century bit, forgets the tracked year, and reloads the RTC-well configuration bits with their default pattern. The ordinary system reset only silences the interrupt request. The status bits, the configuration bits and the year tracking all survive it.

The year tracking is a three-state machine:
- `YW_CLEARED` is entered whenever the RTC reset is low.
- `YW_TRACK` means the last year value was not 99h.
- `YW_ARMED` means the last year value was 99h.

The transitions are:
- From `YW_CLEARED` or `YW_TRACK`, a year write of 99h moves to `YW_ARMED`, and any other year write moves to `YW_TRACK`.
- In `YW_ARMED`, another 99h stays in `YW_ARMED`, and any other year value returns to `YW_TRACK`.
- The edge from `YW_ARMED` to `YW_TRACK` caused by a 00h write is the rollover.
- Writes to other register indices never move the machine.

Top module: `rtc_century_status`

## Requirements
- R1: A rollover is detected only when a write to register index 09h carries 00h and the previous value written to that index was 99h (BCD). After an RTC reset the previous year counts as 00h.
- R2: On the edge that accepts a rollover write, `cent_sts` becomes 1 whatever the power state, and it stays 1 until it is cleared.
- R3: When `pwr_state` is 0 (S0, fully on) on the rollover edge, `smi_req` is 1 for exactly the following cycle.
- R4: When `pwr_state` is any code from 1 to 7 on the rollover edge, no request is issued. A later move to code 0 produces no delayed request.
- R5: A cycle with `clr_en` high clears `cent_sts` when `clr_mask` bit 0 is 1 and clears `pwr_sts` when bit 1 is 1. Zero mask bits have no effect. A rollover in the same cycle keeps `cent_sts` at 1.
- R6: `rtc_rst_n` low at an edge sets `pwr_sts` to 1, even against a clear in that cycle. It also clears `cent_sts` and resets the year tracking.
- R7: `rtc_rst_n` low at an edge loads `cfg_q` with `CFG_DEFAULT` (A5h by default) and ignores `cfg_wr`. Otherwise `cfg_wr` loads `cfg_wdata`.
- R8: `rst_n` low forces `smi_req` to 0 and suppresses requests. It leaves `cent_sts`, `pwr_sts`, `cfg_q` and the year tracking untouched.
- R9: Writes to other indices leave the armed condition unchanged. A repeated 99h keeps it armed, and any other year value disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| rtc_rst_n | input | 1 | RTC-well reset, active low, sampled on the clock |
| wr_en | input | 1 | Register write or clock update strobe |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | 8 | Written value (BCD for the year) |
| pwr_state | input | 3 | Power state, 0 = S0 through 5 = S5 |
| clr_en | input | 1 | Write-one-to-clear strobe for the status bits |
| clr_mask | input | 2 | Bit 0 clears new-century, bit 1 clears RTC-power |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| cent_sts | output | 1 | Sticky new-century status |
| pwr_sts | output | 1 | Sticky RTC-power status |
| smi_req | output | 1 | One-cycle interrupt request |
| cfg_q | output | CFG_W | RTC-well configuration bits |

## Verification
Two pairs of functions can collide in a single cycle: a rollover write and a new-century clear, and an RTC reset and an RTC-power clear. The bench provokes each pair on purpose by raising both strobes on the same edge. It then expects the setting action to win: `cent_sts` stays 1 in the first case, and `pwr_sts` is 1 in the second. A random phase mixes writes, clears and both resets across all power codes, so the pairs also meet by chance. Each collision is judged by a behavioural model that applies set-over-clear priority.

// File: rtl/rtc_cs_pkg.sv
package rtc_cs_pkg;

    // Year tracking states
    typedef enum logic [1:0] {
        YW_CLEARED = 2'd0,
        YW_TRACK   = 2'd1,
        YW_ARMED   = 2'd2
    } yw_state_e;

    // Power state codes
    typedef enum logic [2:0] {
        PS_S0 = 3'd0,
        PS_S1 = 3'd1,
        PS_S2 = 3'd2,
        PS_S3 = 3'd3,
        PS_S4 = 3'd4,
        PS_S5 = 3'd5
    } pstate_e;

    localparam logic [7:0] BCD_99 = 8'h99;
    localparam logic [7:0] BCD_00 = 8'h00;

    // Positions inside the clear mask
    localparam int CLR_CENT = 0;
    localparam int CLR_PWR  = 1;

endpackage

// File: rtl/rtc_year_watch.sv
module rtc_year_watch
    import rtc_cs_pkg::*;
#(
    parameter int             IDX_W    = 7,
    parameter logic [IDX_W-1:0] YEAR_IDX = 'h09
) (
    input  logic             clk,
    input  logic             well_rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    output logic             rollover
);

    yw_state_e state_q;
    yw_state_e state_d;
    logic      yr_wr;

    assign yr_wr = wr_en && (wr_idx == YEAR_IDX);

    // State register
    always_ff @(posedge clk) begin
        if (!well_rst_n) begin
            state_q <= YW_CLEARED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (yr_wr) begin
            unique case (state_q)
                YW_CLEARED,
                YW_TRACK: state_d = (wr_data == BCD_99) ? YW_ARMED : YW_TRACK;
                YW_ARMED: state_d = (wr_data == BCD_99) ? YW_ARMED : YW_TRACK;
                default:  state_d = YW_TRACK;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rollover = 1'b0;
        unique case (state_q)
            YW_ARMED: rollover = well_rst_n && yr_wr && (wr_data == BCD_00);
            default:  rollover = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_sts_regs.sv
module rtc_sts_regs
    import rtc_cs_pkg::*;
(
    input  logic       clk,
    input  logic       sys_rst_n,
    input  logic       well_rst_n,
    input  logic       rollover,
    input  logic [2:0] pwr_state,
    input  logic       clr_en,
    input  logic [1:0] clr_mask,
    output logic       cent_sts,
    output logic       pwr_sts,
    output logic       smi_req
);

    logic in_s0;
    logic clr_cent;
    logic clr_pwr;

    assign in_s0    = (pwr_state == PS_S0);
    assign clr_cent = clr_en && clr_mask[CLR_CENT];
    assign clr_pwr  = clr_en && clr_mask[CLR_PWR];

    // New-century status: setting wins over clearing
    always_ff @(posedge clk) begin
        if (!well_rst_n) begin
            cent_sts <= 1'b0;
        end else if (rollover) begin
            cent_sts <= 1'b1;
        end else if (clr_cent) begin
            cent_sts <= 1'b0;
        end
    end

    // RTC-power status: set by the well reset only
    always_ff @(posedge clk) begin
        if (!well_rst_n) begin
            pwr_sts <= 1'b1;
        end else if (clr_pwr) begin
            pwr_sts <= 1'b0;
        end
    end

    // Interrupt request pulse, issued only in the fully-on state
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            smi_req <= 1'b0;
        end else begin
            smi_req <= rollover && in_s0;
        end
    end

endmodule

// File: rtl/rtc_well_cfg.sv
module rtc_well_cfg #(
    parameter int               CFG_W       = 8,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 'hA5
) (
    input  logic             clk,
    input  logic             well_rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q
);

    logic [CFG_W-1:0] bits_q;

    for (genvar b = 0; b < CFG_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!well_rst_n) begin
                bits_q[b] <= CFG_DEFAULT[b];
            end else if (cfg_wr) begin
                bits_q[b] <= cfg_wdata[b];
            end
        end
    end

    assign cfg_q = bits_q;

endmodule

// File: rtl/rtc_century_status.sv
module rtc_century_status
    import rtc_cs_pkg::*;
#(
    parameter int               IDX_W       = 7,
    parameter logic [IDX_W-1:0] YEAR_IDX    = 'h09,
    parameter int               CFG_W       = 8,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [2:0]       pwr_state,
    input  logic             clr_en,
    input  logic [1:0]       clr_mask,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             cent_sts,
    output logic             pwr_sts,
    output logic             smi_req,
    output logic [CFG_W-1:0] cfg_q
);

    logic rollover;

    rtc_year_watch #(
        .IDX_W    (IDX_W),
        .YEAR_IDX (YEAR_IDX)
    ) i_year_watch (
        .clk        (clk),
        .well_rst_n (rtc_rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rollover   (rollover)
    );

    rtc_sts_regs i_sts_regs (
        .clk        (clk),
        .sys_rst_n  (rst_n),
        .well_rst_n (rtc_rst_n),
        .rollover   (rollover),
        .pwr_state  (pwr_state),
        .clr_en     (clr_en),
        .clr_mask   (clr_mask),
        .cent_sts   (cent_sts),
        .pwr_sts    (pwr_sts),
        .smi_req    (smi_req)
    );

    rtc_well_cfg #(
        .CFG_W       (CFG_W),
        .CFG_DEFAULT (CFG_DEFAULT)
    ) i_well_cfg (
        .clk        (clk),
        .well_rst_n (rtc_rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_q      (cfg_q)
    );

endmodule

// File: rtl/rtc_century_status_chk.sv
module rtc_century_status_chk #(
    parameter int               IDX_W       = 7,
    parameter logic [IDX_W-1:0] YEAR_IDX    = 'h09,
    parameter int               CFG_W       = 8,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 'hA5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rtc_rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [7:0]       wr_data,
    input logic [2:0]       pwr_state,
    input logic             clr_en,
    input logic [1:0]       clr_mask,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             cent_sts,
    input logic             pwr_sts,
    input logic             smi_req,
    input logic [CFG_W-1:0] cfg_q
);

    // R1: the status rises only after a 00h write to the year index
    p_cent_rise_r1: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        $rose(cent_sts) |-> $past(wr_en && (wr_idx == YEAR_IDX) && (wr_data == 8'h00)));

    // R2: every request comes with the status bit set
    p_smi_sts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> cent_sts);

    // R3: the request lasts a single cycle
    p_smi_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);

    // R4: a request follows only an edge that saw the fully-on code
    p_smi_s0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> ($past(pwr_state) == 3'd0));

    // R5: the power status drops only through its clear bit
    p_pwr_fall_r5: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        $fell(pwr_sts) |-> $past(clr_en && clr_mask[1]));

    // R6: well reset sets power status and clears new-century
    p_well_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_rst_n |=> (pwr_sts && !cent_sts));

    // R7: well reset restores the configuration default
    p_cfg_def_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_rst_n |=> (cfg_q == CFG_DEFAULT));

    // R8: system reset holds the request low
    p_sysrst_r8: assert property (@(posedge clk) disable iff (!rtc_rst_n)
        !rst_n |=> !smi_req);

endmodule

bind rtc_century_status rtc_century_status_chk #(
    .IDX_W       (IDX_W),
    .YEAR_IDX    (YEAR_IDX),
    .CFG_W       (CFG_W),
    .CFG_DEFAULT (CFG_DEFAULT)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rtc_rst_n (rtc_rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .pwr_state (pwr_state),
    .clr_en    (clr_en),
    .clr_mask  (clr_mask),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cent_sts  (cent_sts),
    .pwr_sts   (pwr_sts),
    .smi_req   (smi_req),
    .cfg_q     (cfg_q)
);

// File: tb/test_rtc_century_status.sv
module test_rtc_century_status;

    localparam int         IDX_W = 7;
    localparam int         CFG_W = 8;
    localparam logic [7:0] DEF   = 8'hA5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rtc_rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [7:0]       wr_data = '0;
    logic [2:0]       pwr_state = '0;
    logic             clr_en = 1'b0;
    logic [1:0]       clr_mask = '0;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             cent_sts;
    logic             pwr_sts;
    logic             smi_req;
    logic [CFG_W-1:0] cfg_q;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    int         m_prev = 0;
    bit         m_cent = 0;
    bit         m_pwr = 0;
    bit         m_smi = 0;
    logic [7:0] m_cfg = '0;
    bit         m_ok = 0;

    always #10ns clk = ~clk;

    rtc_century_status #(
        .IDX_W       (IDX_W),
        .YEAR_IDX    (7'h09),
        .CFG_W       (CFG_W),
        .CFG_DEFAULT (DEF)
    ) i_rtc_century_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .rtc_rst_n (rtc_rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .pwr_state (pwr_state),
        .clr_en    (clr_en),
        .clr_mask  (clr_mask),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cent_sts  (cent_sts),
        .pwr_sts   (pwr_sts),
        .smi_req   (smi_req),
        .cfg_q     (cfg_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic step();
        bit roll;
        @(posedge clk);
        roll = 0;
        if (!rtc_rst_n) begin
            m_prev = 0;
            m_cent = 0;
            m_pwr  = 1;
            m_cfg  = DEF;
            m_ok   = 1;
        end else begin
            roll = wr_en && (wr_idx == 7'h09) && (m_prev == 'h99) && (wr_data == 8'h00);
            if (wr_en && (wr_idx == 7'h09)) m_prev = int'(wr_data);
            if (roll) m_cent = 1;
            else if (clr_en && clr_mask[0]) m_cent = 0;
            if (clr_en && clr_mask[1]) m_pwr = 0;
            if (cfg_wr) m_cfg = cfg_wdata;
        end
        m_smi = rst_n && roll && (pwr_state == 3'd0);
        @(negedge clk);
        if (m_ok) begin
            chk("R2 model cent_sts", cent_sts, m_cent);
            chk("R3 model smi_req", smi_req, m_smi);
            chk("R6 model pwr_sts", pwr_sts, m_pwr);
            chk("R7 model cfg_q", cfg_q, m_cfg);
        end
        wr_en  = 0;
        clr_en = 0;
        cfg_wr = 0;
    endtask

    task automatic year(input logic [7:0] v);
        wr_en = 1; wr_idx = 7'h09; wr_data = v;
        step();
    endtask

    task automatic clear(input logic [1:0] m);
        clr_en = 1; clr_mask = m;
        step();
    endtask

    initial begin
        #5ms;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        chk("R6 reset pwr_sts", pwr_sts, 1);
        chk("R6 reset cent_sts", cent_sts, 0);
        chk("R7 reset cfg_q", cfg_q, DEF);
        chk("R8 reset smi_req", smi_req, 0);
        rtc_rst_n = 1; rst_n = 1;
        step();

        clear(2'b10);
        chk("R5 pwr cleared", pwr_sts, 0);
        chk("R5 cent untouched", cent_sts, 0);

        // Rollover in S0
        pwr_state = 3'd0;
        year(8'h98); year(8'h99); year(8'h00);
        chk("R2 cent set", cent_sts, 1);
        chk("R3 smi pulse", smi_req, 1);
        step();
        chk("R3 smi one cycle", smi_req, 0);
        chk("R2 cent sticky", cent_sts, 1);
        clear(2'b01);
        chk("R5 cent cleared", cent_sts, 0);

        // Rollover in S3
        pwr_state = 3'd3;
        year(8'h99); year(8'h00);
        chk("R4 cent set in sleep", cent_sts, 1);
        chk("R4 no smi in sleep", smi_req, 0);
        pwr_state = 3'd0;
        step();
        chk("R4 no late smi", smi_req, 0);
        clear(2'b01);

        // Non-99 predecessor
        year(8'h50); year(8'h00);
        chk("R1 50 to 00 ignored", cent_sts, 0);

        // Disarm and other indices
        year(8'h99); year(8'h98); year(8'h00);
        chk("R9 disarmed by 98", cent_sts, 0);
        year(8'h99); year(8'h99);
        wr_en = 1; wr_idx = 7'h08; wr_data = 8'h00; step();
        chk("R9 other index no rollover", cent_sts, 0);
        year(8'h00);
        chk("R9 armed kept", cent_sts, 1);
        chk("R9 smi", smi_req, 1);
        clear(2'b01);

        // Rollover and clear together
        year(8'h99);
        wr_en = 1; wr_idx = 7'h09; wr_data = 8'h00;
        clr_en = 1; clr_mask = 2'b01;
        step();
        chk("R5 set beats clear", cent_sts, 1);
        clear(2'b01);

        // System reset
        rst_n = 0;
        year(8'h99); year(8'h00);
        chk("R8 smi suppressed", smi_req, 0);
        chk("R8 cent kept", cent_sts, 1);
        chk("R8 cfg kept", cfg_q, DEF);
        rst_n = 1;
        clear(2'b01);

        // Unused power code
        pwr_state = 3'd7;
        year(8'h99); year(8'h00);
        chk("R4 code 7 no smi", smi_req, 0);
        pwr_state = 3'd0;
        clear(2'b01);

        // Config and RTC reset collisions
        cfg_wr = 1; cfg_wdata = 8'h3C; step();
        chk("R7 cfg written", cfg_q, 8'h3C);
        year(8'h99);
        rtc_rst_n = 0;
        cfg_wr = 1; cfg_wdata = 8'hFF;
        clr_en = 1; clr_mask = 2'b10;
        step();
        chk("R6 pwr set over clear", pwr_sts, 1);
        chk("R7 default over write", cfg_q, DEF);
        rtc_rst_n = 1;
        year(8'h00);
        chk("R6 tracking reset", cent_sts, 0);
        chk("R6 no smi after reset", smi_req, 0);
        year(8'h99); year(8'h00);
        chk("R1 rollover after reset", cent_sts, 1);

        // Random mix
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            pwr_state = 3'($urandom_range(0, 7));
            rtc_rst_n = (r < 2) ? 1'b0 : 1'b1;
            rst_n = (r >= 2 && r < 5) ? 1'b0 : 1'b1;
            wr_en = ($urandom_range(0, 1) == 1);
            wr_idx = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h09;
            case ($urandom_range(0, 2))
                0:       wr_data = 8'h00;
                1:       wr_data = 8'h99;
                default: wr_data = 8'($urandom);
            endcase
            clr_en = ($urandom_range(0, 9) == 0);
            clr_mask = 2'($urandom);
            cfg_wr = ($urandom_range(0, 9) == 0);
            cfg_wdata = 8'($urandom);
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule